// File: doc/BRIEF.md
# SPI Master Clock and Framing Delay Scaler

This block times an SPI master frame from the system clock. A frame is a sequence of phases: a lead delay from chip-select assertion to the first clock edge, the bit-clocking phase, a trailing delay from the last clock edge to chip-select release, and an idle gap before the next frame. The controller that drives the data shifter asks for one phase at a time with a start strobe. In the bit phase the block returns a one-cycle enable for every serial-clock edge. In a delay phase it returns a one-cycle done pulse when the delay has elapsed.

Each timing comes from a small index pair: a 2-bit prescaler index and a 4-bit scaler index. The indices select divisors that are not powers of two, so odd clock ratios are available. The serial clock has its own prescaler and scaler tables and a double-rate bit. The three delays share a separate pair of tables but have independent indices. Several attribute sets hold complete timing settings, and each start strobe selects one set. The block captures the selected settings at the start strobe, so reprogramming a set during a phase affects only later phases.

Top module: `spi_tmg_scaler`

## Requirements
- R1: After reset, busy_o, sck_edge_o and delay_done_o are low. Neither pulse output is ever high while busy_o is low.
- R2: The serial-clock prescaler index 0, 1, 2, 3 selects a divide of 2, 3, 5, 7.
- R3: The serial-clock scaler index k selects 2·(k+1) for k = 0..3 and 2^k for k = 4..15.
- R4: With the double-rate bit clear, the serial-clock period P is prescaler × scaler system cycles. sck_edge_o pulses every P/2 cycles. The first pulse comes P/2 cycles after the edge that samples start_i.
- R5: With the double-rate bit set, P is prescaler × scaler / 2. Edge intervals alternate between ceil(P/2), which comes first, and floor(P/2), so the duty cycle may be uneven.
- R6: A delay lasts D = delay prescaler × delay scaler cycles. The delay prescaler index i selects 2i+1 and the delay scaler index k selects 2^(k+1). delay_done_o is high for exactly one cycle, D cycles after the sampling edge. busy_o falls in the following cycle.
- R7: phase_i encodes 0 = lead, 1 = bit clocking, 2 = trailing, 3 = gap. The lead, trailing and gap phases use delay slots 0, 1 and 2 of dly_pre_i and dly_scl_i.
- R8: set_sel_i, sampled with start_i, chooses which attribute set supplies all the divisors for that phase.
- R9: Changes to set_sel_i or to any divisor input after the start strobe do not affect the running phase.
- R10: stop_i, when start_i is low, ends the current phase. busy_o goes low in the next cycle, and no further pulses appear.
- R11: delay_done_o never pulses during bit clocking, and sck_edge_o never pulses during a delay phase.
- R12: A start strobe during an active phase restarts timing from the new phase and settings. Nothing from the abandoned phase appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the phase given by phase_i |
| stop_i | input | 1 | Ends the current phase |
| phase_i | input | 2 | Phase code (R7) |
| set_sel_i | input | SEL_W | Attribute set select |
| br_pre_i | input | NSETS×2 | Serial-clock prescaler index per set |
| br_scl_i | input | NSETS×4 | Serial-clock scaler index per set |
| br_dbl_i | input | NSETS | Double-rate bit per set |
| dly_pre_i | input | NSETS×3×2 | Delay prescaler index per set and slot |
| dly_scl_i | input | NSETS×3×4 | Delay scaler index per set and slot |
| sck_edge_o | output | 1 | One-cycle enable per serial-clock edge |
| delay_done_o | output | 1 | One-cycle pulse when a delay ends |
| busy_o | output | 1 | A phase is active |

## Verification
The bench covers every prescaler index and the small scaler indices, where the 2, 4, 6, 8 part of the table departs from powers of two. A wrong table entry would shift every edge of the frame. Double-rate settings with an odd product test the uneven split. A design that rounded the wrong way, or alternated the intervals in the wrong order, would place the first edge one cycle off. Mid-phase reprogramming and set switching catch a design that reads its settings live and stretches or shortens a running phase. Restart and stop tests catch a stale done pulse or stray edge left over from an abandoned phase.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;
  localparam int unsigned PRE_W = 2;
  localparam int unsigned SCL_W = 4;
  localparam int unsigned NDLY  = 3;
  localparam int unsigned CNT_W = 19;

  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_BIT   = 2'd1,
    PH_TRAIL = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;

  function automatic logic [CNT_W-1:0] baud_pre(input logic [PRE_W-1:0] idx);
    case (idx)
      2'd0:    return CNT_W'(2);
      2'd1:    return CNT_W'(3);
      2'd2:    return CNT_W'(5);
      default: return CNT_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] baud_scl(input logic [SCL_W-1:0] idx);
    if (idx < 4) return CNT_W'(2 * (int'(idx) + 1));
    return CNT_W'(1) << idx;
  endfunction

  function automatic logic [CNT_W-1:0] dly_pre(input logic [PRE_W-1:0] idx);
    return CNT_W'(2 * int'(idx) + 1);
  endfunction

  function automatic logic [CNT_W-1:0] dly_scl(input logic [SCL_W-1:0] idx);
    return CNT_W'(1) << (int'(idx) + 1);
  endfunction
endpackage

// File: rtl/spi_tmg_calc.sv
module spi_tmg_calc
  import spi_tmg_pkg::*;
(
  input  logic [PRE_W-1:0]            br_pre_i,
  input  logic [SCL_W-1:0]            br_scl_i,
  input  logic                        br_dbl_i,
  input  logic [NDLY-1:0][PRE_W-1:0]  dly_pre_i,
  input  logic [NDLY-1:0][SCL_W-1:0]  dly_scl_i,
  output logic [CNT_W-1:0]            ivl_a_o,
  output logic [CNT_W-1:0]            ivl_b_o,
  output logic [NDLY-1:0][CNT_W-1:0]  dly_len_o
);
  logic [CNT_W-1:0] prod, period;

  assign prod    = CNT_W'(baud_pre(br_pre_i) * baud_scl(br_scl_i));
  assign period  = br_dbl_i ? (prod >> 1) : prod;
  // longer half first when period is odd
  assign ivl_b_o = period >> 1;
  assign ivl_a_o = period - ivl_b_o;

  for (genvar d = 0; d < NDLY; d++) begin : g_dly
    assign dly_len_o[d] = CNT_W'(dly_pre(dly_pre_i[d]) * dly_scl(dly_scl_i[d]));
  end
endmodule

// File: rtl/spi_tmg_seq.sv
module spi_tmg_seq
  import spi_tmg_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic [1:0]                 phase_i,
  input  logic [CNT_W-1:0]           ivl_a_i,
  input  logic [CNT_W-1:0]           ivl_b_i,
  input  logic [NDLY-1:0][CNT_W-1:0] dly_len_i,
  output logic                       sck_edge_o,
  output logic                       done_o,
  output logic                       busy_o
);
  phase_e           ph_q;
  logic             active_q, half_q, tick;
  logic [CNT_W-1:0] cnt_q, a_q, b_q, dly_sel;

  always_comb begin
    case (phase_e'(phase_i))
      PH_TRAIL: dly_sel = dly_len_i[1];
      PH_GAP:   dly_sel = dly_len_i[2];
      default:  dly_sel = dly_len_i[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      ph_q     <= PH_LEAD;
      cnt_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      half_q   <= 1'b0;
      ph_q     <= phase_e'(phase_i);
      a_q      <= ivl_a_i;
      b_q      <= ivl_b_i;
      cnt_q    <= (phase_e'(phase_i) == PH_BIT) ? ivl_a_i - 1'b1 : dly_sel - 1'b1;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (tick) begin
      if (ph_q == PH_BIT) begin
        half_q <= ~half_q;
        cnt_q  <= (half_q ? a_q : b_q) - 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick       = active_q && (cnt_q == '0);
  assign sck_edge_o = tick && (ph_q == PH_BIT);
  assign done_o     = tick && (ph_q != PH_BIT);
  assign busy_o     = active_q;
endmodule

// File: rtl/spi_tmg_scaler.sv
module spi_tmg_scaler
  import spi_tmg_pkg::*;
#(
  parameter int unsigned NSETS = 2,
  localparam int unsigned SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   start_i,
  input  logic                                   stop_i,
  input  logic [1:0]                             phase_i,
  input  logic [SEL_W-1:0]                       set_sel_i,
  input  logic [NSETS-1:0][PRE_W-1:0]            br_pre_i,
  input  logic [NSETS-1:0][SCL_W-1:0]            br_scl_i,
  input  logic [NSETS-1:0]                       br_dbl_i,
  input  logic [NSETS-1:0][NDLY-1:0][PRE_W-1:0]  dly_pre_i,
  input  logic [NSETS-1:0][NDLY-1:0][SCL_W-1:0]  dly_scl_i,
  output logic                                   sck_edge_o,
  output logic                                   delay_done_o,
  output logic                                   busy_o
);
  logic [CNT_W-1:0]           ivl_a_s [NSETS];
  logic [CNT_W-1:0]           ivl_b_s [NSETS];
  logic [NDLY-1:0][CNT_W-1:0] dly_s   [NSETS];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    spi_tmg_calc u_calc (
      .br_pre_i  (br_pre_i[s]),
      .br_scl_i  (br_scl_i[s]),
      .br_dbl_i  (br_dbl_i[s]),
      .dly_pre_i (dly_pre_i[s]),
      .dly_scl_i (dly_scl_i[s]),
      .ivl_a_o   (ivl_a_s[s]),
      .ivl_b_o   (ivl_b_s[s]),
      .dly_len_o (dly_s[s])
    );
  end

  logic [CNT_W-1:0]           ivl_a, ivl_b;
  logic [NDLY-1:0][CNT_W-1:0] dly_len;

  always_comb begin
    ivl_a   = ivl_a_s[0];
    ivl_b   = ivl_b_s[0];
    dly_len = dly_s[0];
    for (int s = 1; s < NSETS; s++) begin
      if (int'(set_sel_i) == s) begin
        ivl_a   = ivl_a_s[s];
        ivl_b   = ivl_b_s[s];
        dly_len = dly_s[s];
      end
    end
  end

  spi_tmg_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .phase_i    (phase_i),
    .ivl_a_i    (ivl_a),
    .ivl_b_i    (ivl_b),
    .dly_len_i  (dly_len),
    .sck_edge_o (sck_edge_o),
    .done_o     (delay_done_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/spi_tmg_scaler_chk.sv
module spi_tmg_scaler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic sck_edge_o,
  input logic delay_done_o,
  input logic busy_o
);
  // R11
  edge_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sck_edge_o && delay_done_o));

  // R1
  pulse_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_edge_o || delay_done_o) |-> busy_o);

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_done_o |=> !delay_done_o);

  // R6
  done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delay_done_o && !start_i) |=> !busy_o);

  // R10
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!busy_o && !sck_edge_o && !delay_done_o));

  // R12
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

bind spi_tmg_scaler spi_tmg_scaler_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .sck_edge_o   (sck_edge_o),
  .delay_done_o (delay_done_o),
  .busy_o       (busy_o)
);

// File: tb/spi_tmg_scaler_bench.sv
module spi_tmg_scaler_bench;
  localparam int NSETS = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic [1:0] phase_i = 2'd0;
  logic [0:0] set_sel_i = 1'b0;
  logic [NSETS-1:0][1:0]      br_pre_i = '0;
  logic [NSETS-1:0][3:0]      br_scl_i = '0;
  logic [NSETS-1:0]           br_dbl_i = '0;
  logic [NSETS-1:0][2:0][1:0] dly_pre_i = '0;
  logic [NSETS-1:0][2:0][3:0] dly_scl_i = '0;
  logic sck_edge_o, delay_done_o, busy_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  spi_tmg_scaler #(.NSETS(NSETS)) u_spi_tmg_scaler (
    .clk_i, .rst_ni, .start_i, .stop_i, .phase_i, .set_sel_i,
    .br_pre_i, .br_scl_i, .br_dbl_i, .dly_pre_i, .dly_scl_i,
    .sck_edge_o, .delay_done_o, .busy_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bp(input int i);
    case (i)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction
  function automatic int bs(input int k);
    return (k < 4) ? 2 * (k + 1) : (1 << k);
  endfunction
  function automatic int dlen(input int s, input int slot);
    return (2 * int'(dly_pre_i[s][slot]) + 1) * (1 << (int'(dly_scl_i[s][slot]) + 1));
  endfunction
  function automatic int period(input int s);
    int p = bp(int'(br_pre_i[s])) * bs(int'(br_scl_i[s]));
    return br_dbl_i[s] ? p / 2 : p;
  endfunction
  function automatic int slot_of(input int ph);
    return (ph == 2) ? 1 : (ph == 3) ? 2 : 0;
  endfunction

  task automatic issue(input int s, input int ph);
    set_sel_i = 1'(s);
    phase_i   = 2'(ph);
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
  endtask

  // delay phase; mut reprograms the set mid-phase (R9)
  task automatic run_delay(input int s, input int ph, input bit mut);
    int d = dlen(s, slot_of(ph));
    int first = -1;
    int ndone = 0;
    int nedge = 0;
    logic [1:0] sp = dly_pre_i[s][slot_of(ph)];
    logic [3:0] ss = dly_scl_i[s][slot_of(ph)];
    issue(s, ph);
    for (int n = 1; n <= d + 1; n++) begin
      if (delay_done_o) begin ndone++; if (first < 0) first = n; end
      if (sck_edge_o) nedge++;
      if (n == d + 1) chk(!busy_o, "R6 busy after done", busy_o, 0);
      if (mut && n == 2) begin
        dly_pre_i[s][slot_of(ph)] = ~sp;
        dly_scl_i[s][slot_of(ph)] = ss + 4'd1;
        set_sel_i = ~set_sel_i;
      end
      if (n <= d) @(negedge clk_i);
    end
    chk(first == d, mut ? "R9 delay length" : "R6 R7 R8 delay length", first, d);
    chk(ndone == 1, "R6 single done", ndone, 1);
    chk(nedge == 0, "R11 no edge in delay", nedge, 0);
    dly_pre_i[s][slot_of(ph)] = sp;
    dly_scl_i[s][slot_of(ph)] = ss;
  endtask

  // bit clocking for ne edges, then stop (R10)
  task automatic run_bit(input int s, input int ne, input bit mut);
    int p = period(s);
    int a = p - p / 2;
    int b = p / 2;
    int et[8];
    int cnt = 0;
    int ndone = 0;
    int last = 0;
    logic [1:0] sp = br_pre_i[s];
    logic [3:0] ss = br_scl_i[s];
    logic sd = br_dbl_i[s];
    for (int i = 0; i < ne; i++) last += (i % 2 == 0) ? a : b;
    issue(s, 1);
    for (int n = 1; n <= last + 1 && cnt < ne; n++) begin
      if (sck_edge_o) begin et[cnt] = n; cnt++; end
      if (delay_done_o) ndone++;
      if (mut && n == 1) begin
        br_pre_i[s] = ~sp;
        br_scl_i[s] = ss ^ 4'd3;
        br_dbl_i[s] = ~sd;
        set_sel_i   = ~set_sel_i;
      end
      @(negedge clk_i);
    end
    chk(cnt == ne, "R4 edge count", cnt, ne);
    begin
      int exp_t = 0;
      for (int i = 0; i < cnt; i++) begin
        exp_t += (i % 2 == 0) ? a : b;
        chk(et[i] == exp_t,
            mut ? "R9 edge time" : (sd ? "R5 R2 R3 edge time" : "R4 R2 R3 edge time"),
            et[i], exp_t);
      end
    end
    chk(ndone == 0, "R11 no done in bit phase", ndone, 0);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    chk(!busy_o, "R10 busy after stop", busy_o, 0);
    begin
      int stray = 0;
      for (int n = 0; n < p + 2; n++) begin
        if (sck_edge_o || delay_done_o || busy_o) stray++;
        @(negedge clk_i);
      end
      chk(stray == 0, "R10 quiet after stop", stray, 0);
    end
    br_pre_i[s] = sp;
    br_scl_i[s] = ss;
    br_dbl_i[s] = sd;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !sck_edge_o && !delay_done_o, "R1 in reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o, "R1 busy after reset", busy_o, 0);
    chk(!sck_edge_o && !delay_done_o, "R1 pulses after reset", sck_edge_o, 0);

    // R2 every prescaler, R3 small scalers
    for (int i = 0; i < 4; i++) begin
      br_pre_i[0] = 2'(i); br_scl_i[0] = 4'd0; br_dbl_i[0] = 1'b0;
      run_bit(0, 4, 1'b0);
    end
    for (int k = 0; k < 8; k++) begin
      br_pre_i[1] = 2'd0; br_scl_i[1] = 4'(k); br_dbl_i[1] = 1'b0;
      run_bit(1, 4, 1'b0);
    end
    br_pre_i[1] = 2'd3; br_scl_i[1] = 4'd11;
    run_bit(1, 3, 1'b0);

    // R5 odd double-rate periods
    br_pre_i[0] = 2'd1; br_scl_i[0] = 4'd0; br_dbl_i[0] = 1'b1;
    run_bit(0, 6, 1'b0);
    br_pre_i[0] = 2'd3; br_scl_i[0] = 4'd0; br_dbl_i[0] = 1'b1;
    run_bit(0, 6, 1'b0);
    br_pre_i[0] = 2'd2; br_scl_i[0] = 4'd2; br_dbl_i[0] = 1'b1;
    run_bit(0, 6, 1'b0);

    // R7 R8 distinct slots in two sets
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 3; d++) begin
        dly_pre_i[s][d] = 2'((s + d) % 4);
        dly_scl_i[s][d] = 4'(d + 2 * s);
      end
    for (int s = 0; s < 2; s++) begin
      run_delay(s, 0, 1'b0);
      run_delay(s, 2, 1'b0);
      run_delay(s, 3, 1'b0);
    end
    // R6 long delay
    dly_pre_i[1][2] = 2'd0; dly_scl_i[1][2] = 4'd14;
    run_delay(1, 3, 1'b0);

    // R9 reprogram during phase
    dly_pre_i[0][2] = 2'd1; dly_scl_i[0][2] = 4'd2;
    run_delay(0, 3, 1'b1);
    br_pre_i[0] = 2'd1; br_scl_i[0] = 4'd1; br_dbl_i[0] = 1'b0;
    run_bit(0, 5, 1'b1);

    // R12 restart lead with trail
    begin
      int d2, first, ndone;
      dly_pre_i[0][0] = 2'd3; dly_scl_i[0][0] = 4'd4;
      dly_pre_i[1][1] = 2'd0; dly_scl_i[1][1] = 4'd3;
      d2 = dlen(1, 1);
      first = -1; ndone = 0;
      issue(0, 0);
      @(negedge clk_i); @(negedge clk_i);
      issue(1, 2);
      for (int n = 1; n <= d2 + 1; n++) begin
        if (delay_done_o) begin ndone++; if (first < 0) first = n; end
        if (n == d2 + 1) chk(!busy_o, "R12 busy end", busy_o, 0);
        if (n <= d2) @(negedge clk_i);
      end
      chk(first == d2, "R12 restart timing", first, d2);
      chk(ndone == 1, "R12 single done", ndone, 1);
      repeat (dlen(0, 0)) begin
        if (delay_done_o || busy_o) ndone++;
        @(negedge clk_i);
      end
      chk(ndone == 1, "R12 no stale done", ndone, 1);
    end

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int s = int'($urandom_range(1, 0));
      int ph = int'($urandom_range(3, 0));
      br_pre_i[s]  = 2'($urandom_range(3, 0));
      br_scl_i[s]  = 4'($urandom_range(5, 0));
      br_dbl_i[s]  = 1'($urandom_range(1, 0));
      for (int d = 0; d < 3; d++) begin
        dly_pre_i[s][d] = 2'($urandom_range(3, 0));
        dly_scl_i[s][d] = 4'($urandom_range(5, 0));
      end
      if (ph == 1) run_bit(s, 5, 1'b0);
      else run_delay(s, ph, 1'($urandom_range(1, 0)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule